// File: doc/BRIEF.md
# Packed BCD Add/Subtract Unit

This block performs decimal arithmetic on packed binary-coded-decimal operands. Each 4-bit nibble holds one decimal digit. The block computes a destination operand plus or minus a source operand. An incoming carry flag can optionally take part: as a carry in the add form, and as an inverted borrow in the subtract form. It works on either a narrow operand of two digits (one byte) or a wide operand of four digits (one 16-bit word).

The arithmetic core is purely combinational. It is a chain of per-digit slices, and each slice applies its own decimal correction and passes a decimal carry or borrow to the next digit up. A thin registered stage captures the result, the outgoing carry and a zero indication whenever the valid strobe is high, and raises an output valid one cycle later. Operand fetch and write-back stay outside the block. Inputs that are not valid BCD give results that are not meaningful but are fully deterministic.

Top module: `bcd_arith_unit`

## Requirements
- R1: With opSel = 0 (plain add), the result is the decimal sum dstOp + srcOp taken modulo 10^n, where n is the digit count of the selected size. carryOut is 1 exactly when the true sum exceeds the largest n-digit value.
- R2: With opSel = 1 (add with carry), carryIn is added as an extra unit into the lowest digit, and carryOut follows the rule of R1.
- R3: With opSel = 2 (plain subtract), the result is dstOp - srcOp modulo 10^n in decimal. carryOut is 1 when no borrow leaves the top digit, that is, when dstOp >= srcOp.
- R4: With opSel = 3 (subtract with borrow), one extra unit is subtracted when carryIn = 0 and none when carryIn = 1. carryOut follows the rule of R3.
- R5: With wordMode = 0 (byte size, two digits), only bits 7:0 of each operand take part. Result bits 15:8 are 0, and the carry boundary is 99.
- R6: With wordMode = 1 (word size, four digits), all 16 bits take part, and the carry boundary is 9999.
- R7: zeroOut is 1 exactly when every digit of the captured result is 0. This includes a wrap to zero that produces a carry.
- R8: For opSel = 0 and opSel = 2, the value of carryIn has no effect on result or carryOut.
- R9: When inValid is high at a clock edge, result, carryOut and zeroOut take the new values at that edge, and outValid is high for the following cycle only. Without inValid the outputs hold their values and outValid is 0.
- R10: After reset, outValid, result, carryOut and zeroOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Capture strobe for a new operation |
| opSel | input | 2 | Operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow |
| wordMode | input | 1 | 1 selects four digits, 0 selects two digits |
| dstOp | input | 16 | Destination operand (minuend or addend) |
| srcOp | input | 16 | Source operand |
| carryIn | input | 1 | Incoming carry flag |
| outValid | output | 1 | High the cycle after a capture |
| result | output | 16 | Registered packed BCD result |
| carryOut | output | 1 | Registered carry (add) or not-borrow (subtract) |
| zeroOut | output | 1 | Registered all-digits-zero indication |

## Verification
The bench builds the block with its default of four digits for word size and two digits for byte size. With these values both carry boundaries, 99 and 9999, can be reached with directed operands, as can full-width borrow wraps such as 0000 minus 9999 with borrow. Keeping the narrow width strictly below the wide width also exposes the forced-zero upper byte and the ignored upper operand bits to checks at the result port.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDC = 2'd1,
    OP_SUB  = 2'd2,
    OP_SUBB = 2'd3
  } bcdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic isSub;
    logic chainIn;
    logic wordSel;
    logic capture;
  } bcdStrobe_t;

endpackage

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice (
  input  logic       isSub,
  input  logic [3:0] aDig,
  input  logic [3:0] bDig,
  input  logic       chainIn,
  output logic [3:0] resDig,
  output logic       chainOut
);

  logic [4:0] rawVal;
  logic [4:0] fixedVal;
  logic       needFix;

  always_comb begin
    if (isSub) begin
      rawVal   = {1'b0, aDig} - {1'b0, bDig} - {4'b0, chainIn};
      needFix  = rawVal[4];
      fixedVal = needFix ? (rawVal - 5'd6) : rawVal;
    end else begin
      rawVal   = {1'b0, aDig} + {1'b0, bDig} + {4'b0, chainIn};
      needFix  = (rawVal > 5'd9);
      fixedVal = needFix ? (rawVal + 5'd6) : rawVal;
    end
    resDig   = fixedVal[3:0];
    chainOut = needFix;
  end

  // R1 R3: valid decimal digits in give a valid decimal digit out
  always_comb begin
    if (aDig <= 4'd9 && bDig <= 4'd9) begin
      digit_range_chk: assert (resDig <= 4'd9);
    end
  end

endmodule

// File: rtl/bcd_datapath.sv
module bcd_datapath
  import bcd_pkg::*;
#(
  parameter int NUM_DIGITS    = 4,
  parameter int NARROW_DIGITS = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bcdStrobe_t              strb,
  input  logic [4*NUM_DIGITS-1:0] dstOp,
  input  logic [4*NUM_DIGITS-1:0] srcOp,
  output logic [4*NUM_DIGITS-1:0] resReg,
  output logic                    carryReg,
  output logic                    zeroReg
);

  localparam int W = 4 * NUM_DIGITS;

  logic [NUM_DIGITS:0] chain;
  logic [W-1:0]        rawRes;
  logic [W-1:0]        keepMask;
  logic [W-1:0]        maskedRes;
  logic                topChain;
  logic                carryFlag;

  assign chain[0] = strb.chainIn;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    bcd_digit_slice u_slice (
      .isSub   (strb.isSub),
      .aDig    (dstOp[4*g +: 4]),
      .bDig    (srcOp[4*g +: 4]),
      .chainIn (chain[g]),
      .resDig  (rawRes[4*g +: 4]),
      .chainOut(chain[g+1])
    );
    if (g < NARROW_DIGITS) begin : g_low
      assign keepMask[4*g +: 4] = 4'hF;
    end else begin : g_high
      assign keepMask[4*g +: 4] = {4{strb.wordSel}};
    end
  end

  assign maskedRes = rawRes & keepMask;
  assign topChain  = strb.wordSel ? chain[NUM_DIGITS] : chain[NARROW_DIGITS];
  assign carryFlag = strb.isSub ? ~topChain : topChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg   <= '0;
      carryReg <= 1'b0;
      zeroReg  <= 1'b0;
    end else if (strb.capture) begin
      resReg   <= maskedRes;
      carryReg <= carryFlag;
      zeroReg  <= (maskedRes == '0);
    end
  end

  localparam logic [W-1:0] UPPER_MASK = ~((W)'((64'd1 << (4 * NARROW_DIGITS)) - 64'd1));

  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.wordSel) |=> ((resReg & UPPER_MASK) == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(resReg) && $stable(carryReg) && $stable(zeroReg)));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (zeroReg == (resReg == '0)));

endmodule

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
  import bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic       wordMode,
  input  logic       carryIn,
  output bcdStrobe_t strb,
  output logic       outValid
);

  bcdOp_e opCode;
  assign opCode = bcdOp_e'(opSel);

  always_comb begin
    strb.isSub   = (opCode == OP_SUB) || (opCode == OP_SUBB);
    strb.wordSel = wordMode;
    strb.capture = inValid;
    unique case (opCode)
      OP_ADDC: strb.chainIn = carryIn;
      OP_SUBB: strb.chainIn = ~carryIn;
      default: strb.chainIn = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
  import bcd_pkg::*;
#(
  parameter int NUM_DIGITS    = 4,
  parameter int NARROW_DIGITS = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [1:0]              opSel,
  input  logic                    wordMode,
  input  logic [4*NUM_DIGITS-1:0] dstOp,
  input  logic [4*NUM_DIGITS-1:0] srcOp,
  input  logic                    carryIn,
  output logic                    outValid,
  output logic [4*NUM_DIGITS-1:0] result,
  output logic                    carryOut,
  output logic                    zeroOut
);

  bcdStrobe_t strb;

  bcd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opSel   (opSel),
    .wordMode(wordMode),
    .carryIn (carryIn),
    .strb    (strb),
    .outValid(outValid)
  );

  bcd_datapath #(
    .NUM_DIGITS   (NUM_DIGITS),
    .NARROW_DIGITS(NARROW_DIGITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dstOp   (dstOp),
    .srcOp   (srcOp),
    .resReg  (result),
    .carryReg(carryOut),
    .zeroReg (zeroOut)
  );

endmodule

// File: tb/test_bcd_arith_unit.sv
module test_bcd_arith_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic        wordMode = 1'b0;
  logic [15:0] dstOp = '0;
  logic [15:0] srcOp = '0;
  logic        carryIn = 1'b0;
  logic        outValid;
  logic [15:0] result;
  logic        carryOut;
  logic        zeroOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcd_arith_unit i_bcd_arith_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .wordMode(wordMode), .dstOp(dstOp), .srcOp(srcOp), .carryIn(carryIn),
    .outValid(outValid), .result(result), .carryOut(carryOut), .zeroOut(zeroOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bcdToInt(input logic [15:0] v, input int nd);
    int acc = 0;
    for (int i = nd - 1; i >= 0; i--) acc = acc * 10 + int'(v[4*i +: 4]);
    return acc;
  endfunction

  function automatic logic [15:0] intToBcd(input int v);
    logic [15:0] r = '0;
    int t = v;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [15:0] randBcd();
    logic [15:0] r;
    for (int i = 0; i < 4; i++) r[4*i +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  // drive one operation, check captured outputs and the following hold cycle
  task automatic runOp(input logic [1:0] op, input bit word, input logic [15:0] d,
                       input logic [15:0] s, input bit cin, input string req);
    int nd, modv, dv, sv, val;
    bit expC;
    logic [15:0] expR;
    nd   = word ? 4 : 2;
    modv = word ? 10000 : 100;
    dv   = bcdToInt(d, nd);
    sv   = bcdToInt(s, nd);
    if (op[1] == 1'b0) begin
      val  = dv + sv + ((op == 2'd1) ? int'(cin) : 0);
      expC = (val >= modv);
      val  = val % modv;
    end else begin
      val  = dv - sv - ((op == 2'd3) ? int'(!cin) : 0);
      expC = (val >= 0);
      if (val < 0) val += modv;
    end
    expR = intToBcd(val);
    @(negedge clk);
    opSel = op; wordMode = word; dstOp = d; srcOp = s; carryIn = cin; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1, "R9", "outValid after capture", int'(outValid), 1);
    chk(result == expR, req, "result", int'(result), int'(expR));
    chk(carryOut == expC, req, "carryOut", int'(carryOut), int'(expC));
    chk(zeroOut == (val == 0), "R7", "zeroOut", int'(zeroOut), int'(val == 0));
    dstOp = randBcd(); srcOp = randBcd(); carryIn = ~carryIn;
    @(negedge clk);
    chk(outValid == 1'b0, "R9", "outValid idle", int'(outValid), 0);
    chk(result == expR, "R9", "result held", int'(result), int'(expR));
  endtask

  task automatic testReset();
    chk(outValid == 0 && result == 0 && carryOut == 0 && zeroOut == 0, "R10",
        "reset state", int'({outValid, carryOut, zeroOut, result}), 0);
  endtask

  task automatic testAdd();
    runOp(2'd0, 1'b0, 16'h0027, 16'h0015, 1'b0, "R1");  // 42, digit fix
    runOp(2'd0, 1'b0, 16'h0058, 16'h0047, 1'b0, "R1");  // carry beyond 99
    runOp(2'd0, 1'b1, 16'h1234, 16'h5678, 1'b0, "R1");
  endtask

  task automatic testAddCarry();
    runOp(2'd1, 1'b0, 16'h0099, 16'h0000, 1'b1, "R2");  // 99+1 wraps to 00
    runOp(2'd1, 1'b1, 16'h0199, 16'h0800, 1'b1, "R2");
    runOp(2'd1, 1'b1, 16'h4444, 16'h1111, 1'b0, "R2");
  endtask

  task automatic testSub();
    runOp(2'd2, 1'b0, 16'h0042, 16'h0017, 1'b0, "R3");
    runOp(2'd2, 1'b0, 16'h0017, 16'h0042, 1'b0, "R3");  // borrow
    runOp(2'd2, 1'b1, 16'h1000, 16'h0001, 1'b0, "R3");  // borrow ripples
  endtask

  task automatic testSubBorrow();
    runOp(2'd3, 1'b0, 16'h0050, 16'h0020, 1'b0, "R4");  // extra 1 taken
    runOp(2'd3, 1'b0, 16'h0050, 16'h0020, 1'b1, "R4");  // no extra
    runOp(2'd3, 1'b1, 16'h0000, 16'h9999, 1'b0, "R4");  // wraps to 0000
  endtask

  task automatic testByteSize();
    runOp(2'd0, 1'b0, 16'h9912, 16'h7734, 1'b0, "R5");  // upper bits ignored
    runOp(2'd0, 1'b0, 16'h0050, 16'h0050, 1'b0, "R5");  // 100 -> 00 carry
    runOp(2'd2, 1'b0, 16'h3300, 16'h0001, 1'b0, "R5");
  endtask

  task automatic testWordSize();
    runOp(2'd0, 1'b1, 16'h9999, 16'h0001, 1'b0, "R6");
    runOp(2'd0, 1'b1, 16'h9998, 16'h0001, 1'b0, "R6");
  endtask

  task automatic testCarryIgnored();
    runOp(2'd0, 1'b1, 16'h2345, 16'h1111, 1'b1, "R8");
    runOp(2'd2, 1'b1, 16'h2345, 16'h1111, 1'b0, "R8");
  endtask

  task automatic testSweep();
    for (int i = 0; i < 48; i++)
      runOp(2'(i % 4), bit'((i / 4) % 2), randBcd(), randBcd(), bit'($urandom % 2),
            (i % 4 == 0) ? "R1" : (i % 4 == 1) ? "R2" : (i % 4 == 2) ? "R3" : "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testAdd();
    testAddCarry();
    testSub();
    testSubBorrow();
    testByteSize();
    testWordSize();
    testCarryIgnored();
    testSweep();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule